// File: doc/BRIEF.md
# Serial DAC Input Interface

This block is the digital front end of a 12-bit voltage-output converter. A host sends a 16-bit word over a three-wire serial link made of a frame select (active low), a serial clock and a data line. While the frame select is low, each falling serial clock edge shifts one bit, most significant first, into a 16-bit shift register. A gating counter accepts sixteen edges per frame and ignores any more. Only the low twelve bits of the word form the converter code. The upper four bits are padding.

The code register feeding the converter can be updated in two ways. In strobed mode the load input stays high during the transfer, and a later falling edge on load moves the captured word into the register. In automatic mode the load input is held low, and the register updates as soon as the sixteenth bit has arrived. The code is two's complement: 0x800 is the most negative value and 0x7FF the most positive. Each update raises a one-cycle strobe. All serial inputs are asynchronous to the system clock. Each passes through a two-flop synchronizer, so the system clock must run at least four times faster than the serial clock.

Top module: `dac_serial_if`

## Requirements
- R1: After reset, code_o is 0x000 (mid-scale) and update_o is 0.
- R2: While frame_n_i is low, each falling edge of sclk_i shifts sdin_i into the word, most significant bit first. Edges while frame_n_i is high shift nothing.
- R3: Only bits 11..0 of the 16-bit word (the last twelve bits sent) reach code_o. The first four bits sent have no effect on it.
- R4: Within one frame, falling sclk_i edges after the sixteenth are ignored. The word keeps the first sixteen bits.
- R5: With load_n_i held low, code_o takes the new code a few system cycles after the sixteenth falling edge, with no further action.
- R6: With load_n_i high during the transfer, code_o stays unchanged after the frame. A later falling edge on load_n_i loads the captured code.
- R7: A frame with fewer than sixteen edges leaves code_o unchanged, even if load_n_i then falls.
- R8: A falling edge on load_n_i with no complete frame since the previous load has no effect.
- R9: update_o pulses for exactly one cycle on each load, and code_o changes only in a cycle where update_o is high.
- R10: A rising frame_n_i clears the bit count, so a frame that follows an aborted one captures sixteen fresh bits.
- R11: Codes are passed through unaltered in two's complement, including the extremes 0x800 and 0x7FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock; data is taken on its falling edge |
| frame_n_i | input | 1 | Frame select, active low |
| sdin_i | input | 1 | Serial data, MSB first |
| load_n_i | input | 1 | Load strobe, active on falling edge; held low selects automatic mode |
| code_o | output | 12 | Latched two's-complement converter code |
| update_o | output | 1 | One-cycle pulse on each code update |

## Verification
The hardest situations to reach from the ports are the ones where a load must not happen. Examples are a falling load edge after an aborted frame, a second load edge with no new frame, and extra clock edges past the sixteenth. The bench builds these from a frame task that takes an arbitrary edge count. It sends short frames, overlong frames whose surplus bits conflict with the word, and repeated load pulses. After each one it checks both the held code and the count of update pulses.

// File: rtl/dac_if_pkg.sv
package dac_if_pkg;
  localparam int unsigned FRAME_BITS = 16;
  localparam int unsigned CODE_BITS  = 12;
  // synchronized input lanes
  localparam int unsigned LN_SCLK  = 0;
  localparam int unsigned LN_FRAME = 1;
  localparam int unsigned LN_SDIN  = 2;
  localparam int unsigned LN_LOAD  = 3;
  localparam int unsigned LANES    = 4;
endpackage

// File: rtl/in_sync.sv
module in_sync #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int unsigned FRAME_BITS = 16,
  localparam int unsigned CNT_W = $clog2(FRAME_BITS + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  active_i,
  input  logic                  sclk_fall_i,
  input  logic                  sdin_i,
  output logic [FRAME_BITS-1:0] word_o,
  output logic                  done_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);

  logic [CNT_W-1:0]      cnt_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic                  done_q;
  logic                  take;

  assign take = active_i && sclk_fall_i && (cnt_q != CNT_FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= take && (cnt_q == CNT_LAST);
      if (!active_i) begin
        cnt_q <= '0;
      end else if (take) begin
        cnt_q <= cnt_q + 1'b1;
        sh_q  <= {sh_q[FRAME_BITS-2:0], sdin_i};
      end
    end
  end

  assign word_o = sh_q;
  assign done_o = done_q;

  assert_gate_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_FULL) |=> $stable(sh_q));
  assert_idle_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (cnt_q == '0));
endmodule

// File: rtl/code_latch.sv
module code_latch #(
  parameter int unsigned CODE_BITS = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 frame_start_i,
  input  logic                 done_i,
  input  logic                 load_lvl_i,
  input  logic                 load_fall_i,
  input  logic [CODE_BITS-1:0] data_i,
  output logic [CODE_BITS-1:0] code_o,
  output logic                 update_o
);
  logic [CODE_BITS-1:0] code_q;
  logic                 upd_q;
  logic                 valid_q;
  logic                 load_now;

  // auto mode on completion with load held low, else strobed by a load fall
  assign load_now = (done_i && !load_lvl_i) || (load_fall_i && valid_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= '0;
      upd_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      upd_q <= load_now;
      if (load_now) code_q <= data_i;
      if (load_now || frame_start_i) valid_q <= 1'b0;
      else if (done_i)               valid_q <= 1'b1;
    end
  end

  assign code_o   = code_q;
  assign update_o = upd_q;

  assert_strobe_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |=> !upd_q);
  assert_code_moves_with_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_q) |-> upd_q);
endmodule

// File: rtl/dac_serial_if.sv
module dac_serial_if
  import dac_if_pkg::*;
#(
  parameter int unsigned FRAME_W = FRAME_BITS,
  parameter int unsigned CODE_W  = CODE_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              frame_n_i,
  input  logic              sdin_i,
  input  logic              load_n_i,
  output logic [CODE_W-1:0] code_o,
  output logic              update_o
);
  logic [LANES-1:0] raw, lvl;
  logic             sclk_prev_q, frame_prev_q, load_prev_q;
  logic             sclk_fall, frame_fall, load_fall;
  logic [FRAME_W-1:0] word;
  logic             done;

  assign raw[LN_SCLK]  = sclk_i;
  assign raw[LN_FRAME] = frame_n_i;
  assign raw[LN_SDIN]  = sdin_i;
  assign raw[LN_LOAD]  = load_n_i;

  in_sync #(.W(LANES), .RST_VAL(4'b1011)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q  <= 1'b1;
      frame_prev_q <= 1'b1;
      load_prev_q  <= 1'b1;
    end else begin
      sclk_prev_q  <= lvl[LN_SCLK];
      frame_prev_q <= lvl[LN_FRAME];
      load_prev_q  <= lvl[LN_LOAD];
    end
  end

  assign sclk_fall  = sclk_prev_q  && !lvl[LN_SCLK];
  assign frame_fall = frame_prev_q && !lvl[LN_FRAME];
  assign load_fall  = load_prev_q  && !lvl[LN_LOAD];

  frame_shifter #(.FRAME_BITS(FRAME_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (!lvl[LN_FRAME]),
    .sclk_fall_i(sclk_fall),
    .sdin_i     (lvl[LN_SDIN]),
    .word_o     (word),
    .done_o     (done)
  );

  code_latch #(.CODE_BITS(CODE_W)) u_latch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_start_i(frame_fall),
    .done_i       (done),
    .load_lvl_i   (lvl[LN_LOAD]),
    .load_fall_i  (load_fall),
    .data_i       (word[CODE_W-1:0]),
    .code_o       (code_o),
    .update_o     (update_o)
  );

  assert_sclk_fall_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_fall |=> !sclk_fall);
  assert_done_in_frame_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> $past(!lvl[LN_FRAME]));
endmodule

// File: tb/tb_dac_serial_if.sv
`timescale 1ns/1ps
module tb_dac_serial_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b1, frame_n = 1'b1, sdin = 1'b0, load_n = 1'b1;
  logic [11:0] code;
  logic        upd;
  int          checks = 0, fails = 0;
  int          upd_cnt = 0, dbl_cnt = 0;
  logic        upd_prev = 1'b0;
  logic [11:0] model = 12'h000;
  bit          done_flag = 1'b0;

  always #10 clk = ~clk;

  dac_serial_if dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .frame_n_i(frame_n),
    .sdin_i(sdin), .load_n_i(load_n), .code_o(code), .update_o(upd)
  );

  always @(posedge clk) begin
    if (rst_n && upd) upd_cnt <= upd_cnt + 1;
    if (rst_n && upd && upd_prev) dbl_cnt <= dbl_cnt + 1;
    upd_prev <= upd;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // frame with nedges falling sclk edges; bits past 16 are the inverse of the last bit
  task automatic send(input logic [15:0] w, input int nedges);
    frame_n = 1'b0;
    cyc(4);
    for (int i = 0; i < nedges; i++) begin
      sdin = (i < 16) ? w[15-i] : ~w[0];
      cyc(4);
      sclk = 1'b0;
      cyc(4);
      sclk = 1'b1;
    end
    cyc(4);
    frame_n = 1'b1;
    cyc(12);
  endtask

  task automatic pulse_load();
    load_n = 1'b0;
    cyc(6);
    load_n = 1'b1;
    cyc(10);
  endtask

  initial begin
    int base;
    cyc(3);
    chk("R1 code reset", code, 12'h000);
    chk("R1 update reset", upd, 0);
    rst_n = 1'b1;
    cyc(5);

    // R2 edges while frame high shift nothing
    for (int i = 0; i < 4; i++) begin sdin = 1'b1; cyc(4); sclk = 1'b0; cyc(4); sclk = 1'b1; end
    cyc(10);
    chk("R2 no capture outside frame", code, 12'h000);

    // R5 R3 R11 automatic mode sweep
    load_n = 1'b0;
    cyc(6);
    for (int k = 0; k < 64; k++) begin
      logic [15:0] w;
      base = upd_cnt;
      w = {4'(k * 7), 12'((k * 12'h041 + 12'h123) & 12'hFFF)};
      send(w, 16);
      chk("R5 R3 auto load code", code, w[11:0]);
      chk("R9 one strobe per load", upd_cnt - base, 1);
    end
    send(16'hF800, 16);
    chk("R11 most negative", code, 12'h800);
    send(16'h07FF, 16);
    chk("R11 most positive", code, 12'h7FF);
    model = 12'h7FF;

    // R7 short frame in auto mode
    base = upd_cnt;
    send(16'h0123, 10);
    chk("R7 short frame auto", code, model);
    chk("R7 short frame no strobe", upd_cnt - base, 0);

    // R10 aborted frame then full frame
    send(16'hFFFF, 7);
    send(16'hA5C3, 16);
    chk("R10 fresh count after abort", code, 12'h5C3);

    // R4 surplus edges ignored
    send(16'h3ABC, 21);
    chk("R4 surplus edges", code, 12'hABC);
    send(16'h0001, 16 + 9);
    chk("R4 surplus edges lsb", code, 12'h001);
    model = 12'h001;

    // R6 strobed mode
    load_n = 1'b1;
    cyc(6);
    base = upd_cnt;
    send(16'h0456, 16);
    chk("R6 held until load", code, model);
    chk("R6 no strobe before load", upd_cnt - base, 0);
    pulse_load();
    chk("R6 load fall loads", code, 12'h456);
    chk("R6 strobe on load", upd_cnt - base, 1);

    // R8 second load without new frame
    base = upd_cnt;
    send(16'h0999, 5);
    pulse_load();
    chk("R7 short frame then load", code, 12'h456);
    pulse_load();
    chk("R8 repeat load no change", code, 12'h456);
    chk("R8 repeat load no strobe", upd_cnt - base, 0);

    for (int k = 0; k < 8; k++) begin
      logic [15:0] w;
      w = 16'(k * 16'h1357 + 16'h0F0F);
      send(w, 16);
      pulse_load();
      chk("R6 strobed sweep", code, w[11:0]);
    end

    chk("R9 strobe width one cycle", dbl_cnt, 0);
    done_flag = 1'b1;
  end

  initial begin
    for (int t = 0; t < 150000; t++) begin
      @(posedge clk);
      if (done_flag) break;
    end
    if (!done_flag) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule